// File: doc/BRIEF.md
# Predicated Vector Element Step Sequencer

This block walks the element loop of a single vector instruction. It holds a source element index, a destination element index, and one sub-element counter for each side. Every accepted advance strobe moves both sides forward by one sub-element. A side's element index moves up by one only after that side's sub-element counter has wrapped. Whenever a side begins a new element (its sub-element counter is 0), that side jumps over every element whose predicate bit is clear, unless that side is in zeroing mode. The skip is a single-cycle priority search.

A start pulse arms the loop. The loop then runs until one of two things happens: either side completes its final sub-element of element VL-1, or either side's skip runs off the end at VL. At that point every counter returns to zero and a one-cycle next-instruction pulse is raised. Per-side masked flags tell the datapath that the current element has a clear predicate bit and needs a zeroing write rather than a computed one. All state is registered, so a start or advance is visible in the cycle after the clock edge that samples it.

Top module: `stepseq_top`

## Requirements
- R1: After synchronous reset all four counters, both masked flags, `busy`, `last` and `next_insn` are 0.
- R2: The sub-vector setting `subvl` (0..3) means `subvl`+1 sub-elements per element. On an accepted advance, each side acts on its own. If its sub-counter equals `subvl`, the sub-counter goes to 0 and its element index increments, unless the index equals VL-1. Otherwise only the sub-counter increments.
- R3: The two sides are independent. Each side skips with its own mask and its own zeroing flag, and each keeps its own sub-counter.
- R4: When a side's sub-counter is 0 after start or after an advance, and its zeroing flag is 0, its index moves to the lowest position at or above the candidate index whose mask bit (bit i for element i) is 1. If no such position below VL exists, the index becomes VL.
- R5: With a side's zeroing flag at 1, no skip happens. The side's masked flag is 1 while busy exactly when that side's mask bit at its current index is 0. It is 0 when idle.
- R6: `last` is 1 while busy when (source index = VL-1 and source sub-counter = `subvl`) or (destination index = VL-1 and destination sub-counter = `subvl`). An advance while `last` is 1 clears all counters and `busy`, and pulses `next_insn` for one cycle.
- R7: If the skip on either side reaches VL, the loop ends in that same update: counters cleared, `busy` 0, `next_insn` pulsed.
- R8: A start with VL = 0 raises `next_insn` in the next cycle and leaves `busy` at 0.
- R9: The advance strobe has no effect while `busy` is 0.
- R10: A start while busy restarts the loop from index 0, and start takes priority over a simultaneous advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new element loop |
| advance | input | 1 | One element issue has been consumed |
| vl | input | 7 | Vector length, 0..64 |
| subvl | input | 2 | Sub-vector setting, sub-elements minus one |
| src_mask | input | 64 | Source predicate, bit i for element i |
| dst_mask | input | 64 | Destination predicate, bit i for element i |
| src_zero | input | 1 | Source zeroing mode (no skip) |
| dst_zero | input | 1 | Destination zeroing mode (no skip) |
| src_idx | output | 7 | Current source element index |
| dst_idx | output | 7 | Current destination element index |
| src_sub | output | 2 | Current source sub-element |
| dst_sub | output | 2 | Current destination sub-element |
| src_masked | output | 1 | Source element has a clear predicate bit |
| dst_masked | output | 1 | Destination element has a clear predicate bit |
| busy | output | 1 | Loop active |
| last | output | 1 | Current step is the final one |
| next_insn | output | 1 | One-cycle pulse: loop finished |

## Verification
The assertions check four invariants on every cycle:
- sub-counters never pass `subvl` while busy;
- a non-zeroing side never rests on an element with a clear predicate bit;
- indices stay below VL while busy;
- a next-instruction pulse always comes with cleared state.

They also check that idle advances change nothing and that a start with VL = 0 finishes at once. The actual order of indices is shown only by the bench scenarios. These cover skip targets across sparse and empty masks, which side ends the loop first, wrap points for every `subvl`, held advances, and restart in mid-loop, all compared against a bench model.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;
  localparam int MAX_ELEMS = 64;
  localparam int SUB_BITS  = 2;
  localparam int NUM_SIDES = 2;   // 0 = source, 1 = destination
  localparam int SIDE_SRC  = 0;
  localparam int SIDE_DST  = 1;
endpackage

// File: rtl/stepseq_ffs.sv
// Lowest set bit of 'bits' inside [lo, hi); returns hi when none is found.
module stepseq_ffs #(
  parameter int N  = 64,
  parameter int IW = $clog2(N) + 1
) (
  input  logic [N-1:0]  bits,
  input  logic [IW-1:0] lo,
  input  logic [IW-1:0] hi,
  output logic [IW-1:0] pos
);
  logic [N-1:0] window;

  for (genvar i = 0; i < N; i++) begin : g_win
    assign window[i] = bits[i] && (IW'(i) >= lo) && (IW'(i) < hi);
  end

  always_comb begin
    pos = hi;
    for (int i = N - 1; i >= 0; i--) begin
      if (window[i]) pos = IW'(i);
    end
  end
endmodule

// File: rtl/stepseq_side.sv
// Next-state logic for one side: sub-element wrap, index step, predicate skip.
module stepseq_side #(
  parameter int N  = 64,
  parameter int IW = $clog2(N) + 1,
  parameter int SW = 2
) (
  input  logic          start,
  input  logic          step,
  input  logic [IW-1:0] idx,
  input  logic [SW-1:0] sub,
  input  logic [SW-1:0] subvl,
  input  logic [IW-1:0] vl,
  input  logic [N-1:0]  mask,
  input  logic          zero,
  output logic [IW-1:0] nidx,
  output logic [SW-1:0] nsub,
  output logic          nmasked,
  output logic          nexh
);
  localparam int PW = $clog2(N);
  localparam logic [IW-1:0] ONE_I = IW'(1);
  localparam logic [SW-1:0] ONE_S = SW'(1);
  localparam logic [IW-1:0] CAP   = IW'(N);

  logic [IW-1:0] cand_idx;
  logic [IW-1:0] hit_idx;
  logic [SW-1:0] cand_sub;

  always_comb begin
    cand_idx = idx;
    cand_sub = sub;
    if (start) begin
      cand_idx = '0;
      cand_sub = '0;
    end else if (step) begin
      if (sub == subvl) begin
        cand_sub = '0;
        if (idx != vl - ONE_I) cand_idx = idx + ONE_I;
      end else begin
        cand_sub = sub + ONE_S;
      end
    end
  end

  stepseq_ffs #(.N(N), .IW(IW)) u_ffs (
    .bits(mask),
    .lo  (cand_idx),
    .hi  (vl),
    .pos (hit_idx)
  );

  assign nidx    = (cand_sub == '0 && !zero) ? hit_idx : cand_idx;
  assign nsub    = cand_sub;
  assign nexh    = nidx >= vl;
  assign nmasked = (nidx < CAP) ? ~mask[nidx[PW-1:0]] : 1'b1;
endmodule

// File: rtl/stepseq_top.sv
module stepseq_top
  import stepseq_pkg::*;
#(
  parameter int N  = MAX_ELEMS,
  parameter int SW = SUB_BITS,
  parameter int IW = $clog2(N) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          advance,
  input  logic [IW-1:0] vl,
  input  logic [SW-1:0] subvl,
  input  logic [N-1:0]  src_mask,
  input  logic [N-1:0]  dst_mask,
  input  logic          src_zero,
  input  logic          dst_zero,
  output logic [IW-1:0] src_idx,
  output logic [IW-1:0] dst_idx,
  output logic [SW-1:0] src_sub,
  output logic [SW-1:0] dst_sub,
  output logic          src_masked,
  output logic          dst_masked,
  output logic          busy,
  output logic          last,
  output logic          next_insn
);
  localparam logic [IW-1:0] ONE_I = IW'(1);

  logic [NUM_SIDES-1:0][IW-1:0] idx_q, idx_n;
  logic [NUM_SIDES-1:0][SW-1:0] sub_q, sub_n;
  logic [NUM_SIDES-1:0][N-1:0]  mask_a;
  logic [NUM_SIDES-1:0]         zero_a, msk_q, msk_n, exh_n, side_end;
  logic busy_q, pulse_q;
  logic adv_ok, step, load, finish;

  assign mask_a[SIDE_SRC] = src_mask;
  assign mask_a[SIDE_DST] = dst_mask;
  assign zero_a[SIDE_SRC] = src_zero;
  assign zero_a[SIDE_DST] = dst_zero;

  for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
    assign side_end[g] = (idx_q[g] == vl - ONE_I) && (sub_q[g] == subvl);

    stepseq_side #(.N(N), .IW(IW), .SW(SW)) u_side (
      .start  (start),
      .step   (step),
      .idx    (idx_q[g]),
      .sub    (sub_q[g]),
      .subvl  (subvl),
      .vl     (vl),
      .mask   (mask_a[g]),
      .zero   (zero_a[g]),
      .nidx   (idx_n[g]),
      .nsub   (sub_n[g]),
      .nmasked(msk_n[g]),
      .nexh   (exh_n[g])
    );
  end

  assign last   = busy_q && (|side_end);
  assign adv_ok = advance && busy_q && !start;
  assign step   = adv_ok && !last;
  assign load   = start || adv_ok;
  assign finish = start ? (|exh_n) : (adv_ok && (last || (|exh_n)));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      sub_q   <= '0;
      msk_q   <= '0;
      busy_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (finish) begin
        idx_q   <= '0;
        sub_q   <= '0;
        msk_q   <= '0;
        busy_q  <= 1'b0;
        pulse_q <= 1'b1;
      end else if (load) begin
        idx_q  <= idx_n;
        sub_q  <= sub_n;
        msk_q  <= msk_n;
        busy_q <= 1'b1;
      end
    end
  end

  assign src_idx    = idx_q[SIDE_SRC];
  assign dst_idx    = idx_q[SIDE_DST];
  assign src_sub    = sub_q[SIDE_SRC];
  assign dst_sub    = sub_q[SIDE_DST];
  assign src_masked = msk_q[SIDE_SRC];
  assign dst_masked = msk_q[SIDE_DST];
  assign busy       = busy_q;
  assign next_insn  = pulse_q;
endmodule

// File: rtl/stepseq_chk.sv
module stepseq_chk #(
  parameter int N  = 64,
  parameter int IW = $clog2(N) + 1,
  parameter int SW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          advance,
  input logic [IW-1:0] vl,
  input logic [SW-1:0] subvl,
  input logic [N-1:0]  src_mask,
  input logic [N-1:0]  dst_mask,
  input logic          src_zero,
  input logic          dst_zero,
  input logic [IW-1:0] src_idx,
  input logic [IW-1:0] dst_idx,
  input logic [SW-1:0] src_sub,
  input logic [SW-1:0] dst_sub,
  input logic          busy,
  input logic          last,
  input logic          next_insn
);
  localparam int PW = $clog2(N);

  assert_sub_bound_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (src_sub <= subvl) && (dst_sub <= subvl));

  assert_src_skip_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !src_zero) |-> src_mask[src_idx[PW-1:0]]);

  assert_dst_skip_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && !dst_zero) |-> dst_mask[dst_idx[PW-1:0]]);

  assert_idx_range_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (src_idx < vl) && (dst_idx < vl));

  assert_done_clear_R6: assert property (@(posedge clk) disable iff (rst)
    next_insn |-> (!busy && src_idx == '0 && dst_idx == '0 &&
                   src_sub == '0 && dst_sub == '0));

  assert_last_busy_R6: assert property (@(posedge clk) disable iff (rst)
    last |-> busy);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start && advance) |=> (!busy && !next_insn && $stable(src_idx) && $stable(dst_idx)));

  assert_vl_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (start && vl == '0) |=> (next_insn && !busy));
endmodule

bind stepseq_top stepseq_chk #(.N(N), .IW(IW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .advance(advance), .vl(vl),
  .subvl(subvl), .src_mask(src_mask), .dst_mask(dst_mask),
  .src_zero(src_zero), .dst_zero(dst_zero), .src_idx(src_idx),
  .dst_idx(dst_idx), .src_sub(src_sub), .dst_sub(dst_sub),
  .busy(busy), .last(last), .next_insn(next_insn)
);

// File: tb/tb_stepseq_top.sv
module tb_stepseq_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        start, advance;
  logic [6:0]  vl;
  logic [1:0]  subvl;
  logic [63:0] src_mask, dst_mask;
  logic        src_zero, dst_zero;
  logic [6:0]  src_idx, dst_idx;
  logic [1:0]  src_sub, dst_sub;
  logic        src_masked, dst_masked, busy, last, next_insn;

  int checks = 0;
  int errors = 0;
  // bench model state
  int m_si, m_di, m_ss, m_ds;
  bit m_busy, m_pulse;

  always #10 clk = ~clk;  // 50 MHz

  stepseq_top dut (
    .clk(clk), .rst(rst), .start(start), .advance(advance), .vl(vl),
    .subvl(subvl), .src_mask(src_mask), .dst_mask(dst_mask),
    .src_zero(src_zero), .dst_zero(dst_zero), .src_idx(src_idx),
    .dst_idx(dst_idx), .src_sub(src_sub), .dst_sub(dst_sub),
    .src_masked(src_masked), .dst_masked(dst_masked), .busy(busy),
    .last(last), .next_insn(next_insn)
  );

  task automatic chk(input string tag, input string name,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (vl=%0d subvl=%0d)",
               tag, name, act, exp, vl, subvl);
    end
  endtask

  function automatic int skip_to(input logic [63:0] m, input int i, input int n);
    int k = i;
    while (k < n && !m[k]) k++;
    return k;
  endfunction

  // Model of one clock edge, built from R2, R4, R6, R7, R10
  task automatic model_edge();
    int  n = int'(vl);
    int  s = int'(subvl);
    bit  fin = 0;
    bit  lst = m_busy && ((m_si == n - 1 && m_ss == s) || (m_di == n - 1 && m_ds == s));
    m_pulse = 0;
    if (start || (advance && m_busy)) begin
      if (start) begin
        m_si = 0; m_di = 0; m_ss = 0; m_ds = 0;
      end else if (lst) begin
        fin = 1;
      end else begin
        if (m_ss == s) begin m_ss = 0; if (m_si != n - 1) m_si++; end
        else m_ss++;
        if (m_ds == s) begin m_ds = 0; if (m_di != n - 1) m_di++; end
        else m_ds++;
      end
      if (!fin) begin
        if (m_ss == 0 && !src_zero) m_si = skip_to(src_mask, m_si, n);
        if (m_ds == 0 && !dst_zero) m_di = skip_to(dst_mask, m_di, n);
        if (m_si >= n || m_di >= n) fin = 1;
      end
      if (fin) begin
        m_si = 0; m_di = 0; m_ss = 0; m_ds = 0; m_busy = 0; m_pulse = 1;
      end else begin
        m_busy = 1;
      end
    end
  endtask

  task automatic compare_all();
    int  n = int'(vl);
    int  s = int'(subvl);
    bit  e_last = m_busy && ((m_si == n - 1 && m_ss == s) || (m_di == n - 1 && m_ds == s));
    bit  e_sm = m_busy ? !src_mask[m_si[5:0]] : 1'b0;
    bit  e_dm = m_busy ? !dst_mask[m_di[5:0]] : 1'b0;
    chk("R4", "src_idx", 64'(src_idx), 64'(m_si));
    chk("R3", "dst_idx", 64'(dst_idx), 64'(m_di));
    chk("R2", "src_sub", 64'(src_sub), 64'(m_ss));
    chk("R2", "dst_sub", 64'(dst_sub), 64'(m_ds));
    chk("R5", "src_masked", 64'(src_masked), 64'(e_sm));
    chk("R5", "dst_masked", 64'(dst_masked), 64'(e_dm));
    chk("R7", "busy", 64'(busy), 64'(m_busy));
    chk("R6", "last", 64'(last), 64'(e_last));
    chk("R6", "next_insn", 64'(next_insn), 64'(m_pulse));
  endtask

  // Called at a negative edge: drive, predict, wait one edge, check.
  task automatic tick(input bit st, input bit adv);
    start = st;
    advance = adv;
    model_edge();
    @(posedge clk);
    @(negedge clk);
    start = 0;
    advance = 0;
    compare_all();
  endtask

  task automatic set_masks(input int p);
    case (p)
      0: begin src_mask = '1; dst_mask = '1; end
      1: begin src_mask = 64'hAAAA_AAAA_AAAA_AAAA; dst_mask = 64'h5555_5555_5555_5555; end
      2: begin src_mask = 64'h8000_0000_0000_0005; dst_mask = 64'hF0F0_F0F0_F0F0_F0F0; end
      default: begin src_mask = 64'h0123_4567_89AB_CDEF; dst_mask = '0; end
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int vls[5] = '{0, 1, 3, 7, 64};
    rst = 1; start = 0; advance = 0; vl = 7'd4; subvl = 2'd0;
    src_mask = '1; dst_mask = '1; src_zero = 0; dst_zero = 0;
    m_si = 0; m_di = 0; m_ss = 0; m_ds = 0; m_busy = 0; m_pulse = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state
    compare_all();
    chk("R1", "reset busy", 64'(busy), 64'd0);

    // R9: advance while idle changes nothing
    tick(0, 1);
    tick(0, 1);

    // Sweep: R2..R8 across subvl, VL, mask pairs, zeroing combinations
    for (int sv = 0; sv < 4; sv++) begin
      for (int vi = 0; vi < 5; vi++) begin
        for (int p = 0; p < 4; p++) begin
          for (int z = 0; z < 4; z++) begin
            subvl = 2'(sv);
            vl = 7'(vls[vi]);
            set_masks(p);
            src_zero = z[0];
            dst_zero = z[1];
            tick(1, 0);            // R8 when vl == 0
            for (int n = 0; n < 400 && m_busy; n++)
              tick(0, (n % 5) != 4);  // held cycles in between
            tick(0, 1);            // R9: idle advance after the loop
          end
        end
      end
    end

    // R10: restart mid-loop, start beats a simultaneous advance
    vl = 7'd10; subvl = 2'd1; src_mask = '1; dst_mask = 64'h3F6;
    src_zero = 0; dst_zero = 0;
    tick(1, 0);
    for (int n = 0; n < 5; n++) tick(0, 1);
    tick(1, 1);
    chk("R10", "restart src_idx", 64'(src_idx), 64'd0);
    for (int n = 0; n < 60 && m_busy; n++) tick(0, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule